// File: doc/BRIEF.md
# Serial Programming Test Access Port

This block is a test access port that serves only as a serial path for writing and reading back a configuration store. It has no boundary-scan cells. The standard sixteen-state controller advances on the rising edge of the test clock under the mode input. An eight-bit instruction register selects which data register sits between the serial input and the serial output.

The data registers are:
- a one-bit bypass stage;
- a fixed identification word;
- an address register;
- a data register;
- a status register that samples six comparator outputs.

A program instruction raises a one-cycle strobe, presenting the latched address and data to the external non-volatile store. A read instruction captures the word the store returns, so that it can be shifted out and verified.

Every boundary-scan opcode, and every opcode that has no meaning here, selects the bypass stage. The device therefore stays well behaved inside a longer scan chain.

Top module: `prog_tap`

## Requirements
- R1: While reset is asserted, and on every entry to Test-Logic-Reset, the current instruction becomes IDCODE (8'h10). After reset, `tdo_en_o`, `prog_strobe_o`, `prog_addr_o` and `prog_data_o` are all 0.
- R2: Five consecutive rising clock edges with the mode input high bring the controller to Test-Logic-Reset from any state.
- R3: In Capture-IR the instruction shift register loads 8'h01, so the first bits shifted out are 1, 0, 0, and so on.
- R4: With BYPASS (8'hFF) selected, Capture-DR loads 0 into the bypass stage. The serial output then repeats the serial input one shift later.
- R5: The boundary-scan opcodes 8'h00, 8'h01, 8'h02 and 8'h03, and any opcode not listed in these requirements, select the bypass stage.
- R6: IDCODE captures the 32-bit identification parameter, whose bit 0 is 1. It is shifted out LSB first.
- R7: STATUS (8'h15) captures `cmp_i` in Capture-DR, bit 0 first.
- R8: ADDR (8'h11) and DATA (8'h12) capture their held values and shift LSB first. In Update-DR they load the held value that drives `prog_addr_o` or `prog_data_o`.
- R9: With PROGRAM (8'h13) in effect, `prog_strobe_o` is high for exactly one cycle after each move from Update-IR or Update-DR into Run-Test/Idle. This includes the Update-IR that loads PROGRAM. The strobe stays low when Update-IR is left towards Select-DR.
- R10: READ (8'h14) captures `rd_data_i` into the data shift register. Its Update-DR leaves `prog_data_o` unchanged.
- R11: `tdo_en_o` is high only while the controller is in Shift-DR or Shift-IR. It and `tdo_o` change on the falling clock edge.
- R12: Asserting `rst_ni` resets the controller asynchronously, at any point, to Test-Logic-Reset, with `tdo_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in |
| cmp_i | input | CMP_N | Live comparator outputs |
| rd_data_i | input | DATA_W | Word read back from the store |
| tdo_o | output | 1 | Serial data out, changes on falling edge |
| tdo_en_o | output | 1 | Output enable for tdo_o (low means high impedance) |
| prog_strobe_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Latched program address |
| prog_data_o | output | DATA_W | Latched program data |

## Verification
The instruction update and the program strobe can act on the same rising edge. When Update-IR loads PROGRAM and the mode input is low, the strobe decision must use the freshly shifted opcode rather than the old one. The bench loads PROGRAM and goes straight to Run-Test/Idle. It then repeats the load, leaving Update-IR towards Select-DR. It counts strobe pulses against a total worked out from the requirement, and compares the address and data seen during each pulse.

// File: rtl/prog_tap_pkg.sv
package prog_tap_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {DR_BYP, DR_ID, DR_ADDR, DR_DATA, DR_STAT} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h01;
  localparam logic [IR_W-1:0] OP_CLAMP  = 8'h02;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h03;
  localparam logic [IR_W-1:0] OP_IDCODE = 8'h10;
  localparam logic [IR_W-1:0] OP_ADDR   = 8'h11;
  localparam logic [IR_W-1:0] OP_DATA   = 8'h12;
  localparam logic [IR_W-1:0] OP_PROG   = 8'h13;
  localparam logic [IR_W-1:0] OP_READ   = 8'h14;
  localparam logic [IR_W-1:0] OP_STAT   = 8'h15;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

  // boundary-scan and unknown opcodes fall to bypass
  function automatic dr_sel_e dr_decode(logic [IR_W-1:0] op);
    case (op)
      OP_IDCODE:        return DR_ID;
      OP_ADDR:          return DR_ADDR;
      OP_DATA, OP_READ: return DR_DATA;
      OP_STAT:          return DR_STAT;
      default:          return DR_BYP;
    endcase
  endfunction

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    case (s)
      S_TLR:    return tms ? S_TLR    : S_RTI;
      S_RTI:    return tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: return tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: return tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  return tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: return tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: return tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: return tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: return tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: return tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: return tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  return tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: return tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: return tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: return tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: return tms ? S_SEL_DR : S_RTI;
      default:  return S_TLR;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import prog_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_TLR;
    else         state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;

  // run of high mode samples, saturating at 5
  logic [2:0] ones_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    ones_q <= '0;
    else if (!tms_i) ones_q <= '0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  p_five_ones_reset_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    ones_q == 3'd5 |-> state_q == S_TLR);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import prog_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic [IR_W-1:0] ir_sr_o
);
  logic [IR_W-1:0] ir_q, sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= OP_IDCODE;
      sr_q <= '0;
    end else begin
      case (state_i)
        S_TLR:    ir_q <= OP_IDCODE;
        S_CAP_IR: sr_q <= {{(IR_W-2){1'b0}}, 2'b01};
        S_SH_IR:  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        S_UPD_IR: ir_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign ir_o    = ir_q;
  assign ir_sr_o = sr_q;

  p_tlr_idcode_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == S_TLR |=> ir_q == OP_IDCODE);
  p_ir_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == S_CAP_IR |=> sr_q[1:0] == 2'b01);
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import prog_tap_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          CMP_N  = 6,
  parameter logic [31:0] IDCODE = 32'h0B5A_7013
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              tdi_i,
  input  logic [CMP_N-1:0]  cmp_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              tdo_o
);
  localparam int ID_W = 32;

  dr_sel_e           sel;
  logic              byp_q;
  logic [ID_W-1:0]   id_sr;
  logic [ADDR_W-1:0] addr_sr, addr_q;
  logic [DATA_W-1:0] data_sr, data_q;
  logic [CMP_N-1:0]  stat_sr;

  assign sel = dr_decode(ir_i);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q   <= 1'b0;
      id_sr   <= '0;
      addr_sr <= '0;
      addr_q  <= '0;
      data_sr <= '0;
      data_q  <= '0;
      stat_sr <= '0;
    end else begin
      case (state_i)
        S_CAP_DR: begin
          case (sel)
            DR_BYP:  byp_q   <= 1'b0;
            DR_ID:   id_sr   <= IDCODE;
            DR_ADDR: addr_sr <= addr_q;
            DR_DATA: data_sr <= (ir_i == OP_READ) ? rd_data_i : data_q;
            DR_STAT: stat_sr <= cmp_i;
            default: ;
          endcase
        end
        S_SH_DR: begin
          case (sel)
            DR_BYP:  byp_q   <= tdi_i;
            DR_ID:   id_sr   <= {tdi_i, id_sr[ID_W-1:1]};
            DR_ADDR: addr_sr <= {tdi_i, addr_sr[ADDR_W-1:1]};
            DR_DATA: data_sr <= {tdi_i, data_sr[DATA_W-1:1]};
            DR_STAT: stat_sr <= {tdi_i, stat_sr[CMP_N-1:1]};
            default: ;
          endcase
        end
        S_UPD_DR: begin
          if (ir_i == OP_ADDR) addr_q <= addr_sr;
          if (ir_i == OP_DATA) data_q <= data_sr;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DR_ID:   tdo_o = id_sr[0];
      DR_ADDR: tdo_o = addr_sr[0];
      DR_DATA: tdo_o = data_sr[0];
      DR_STAT: tdo_o = stat_sr[0];
      default: tdo_o = byp_q;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;

  p_bypass_zero_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_CAP_DR && sel == DR_BYP) |=> byp_q == 1'b0);
  p_status_capture_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_CAP_DR && sel == DR_STAT) |=> stat_sr == $past(cmp_i));
  p_read_keeps_data_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_UPD_DR && ir_i == OP_READ) |=> $stable(data_q));
endmodule

// File: rtl/prog_tap.sv
module prog_tap
  import prog_tap_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          CMP_N  = 6,
  parameter logic [31:0] IDCODE = 32'h0B5A_7013
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic [CMP_N-1:0]  cmp_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  output logic              prog_strobe_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o
);
  tap_state_e      state;
  logic [IR_W-1:0] ir, ir_sr;
  logic            dr_tdo;

  tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  tap_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .tdi_i   (tdi_i),
    .ir_o    (ir),
    .ir_sr_o (ir_sr)
  );

  tap_dr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMP_N  (CMP_N),
    .IDCODE (IDCODE)
  ) u_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .ir_i      (ir),
    .tdi_i     (tdi_i),
    .cmp_i     (cmp_i),
    .rd_data_i (rd_data_i),
    .addr_o    (prog_addr_o),
    .data_o    (prog_data_o),
    .tdo_o     (dr_tdo)
  );

  // Update-IR uses the opcode being loaded in the same edge
  logic strobe_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else strobe_q <= !tms_i &&
                     ((state == S_UPD_IR && ir_sr == OP_PROG) ||
                      (state == S_UPD_DR && ir    == OP_PROG));
  end
  assign prog_strobe_o = strobe_q;

  logic tdo_q, en_q;
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q  <= (state == S_SH_IR) || (state == S_SH_DR);
      tdo_q <= (state == S_SH_IR) ? ir_sr[0] :
               (state == S_SH_DR) ? dr_tdo   : 1'b0;
    end
  end
  assign tdo_o    = tdo_q;
  assign tdo_en_o = en_q;

  p_tdo_en_shift_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state == S_SH_IR || state == S_SH_DR));
  p_strobe_single_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    prog_strobe_o |=> !prog_strobe_o);
  p_strobe_in_idle_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    prog_strobe_o |-> state == S_RTI);
endmodule

// File: tb/prog_tap_test.sv
`timescale 1ns/1ps
module prog_tap_test;
  localparam logic [31:0] ID_VAL = 32'h0B5A_7013;

  logic        tck = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tms_i = 1'b1;
  logic        tdi_i = 1'b0;
  logic [5:0]  cmp_i = '0;
  logic [15:0] rd_data_i = '0;
  logic        tdo_o, tdo_en_o, prog_strobe_o;
  logic [7:0]  prog_addr_o;
  logic [15:0] prog_data_o;

  prog_tap uut (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .cmp_i(cmp_i), .rd_data_i(rd_data_i), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o),
    .prog_strobe_o(prog_strobe_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o)
  );

  always #10 tck = ~tck;

  int n_chk = 0, n_fail = 0, mst = 0, stb_cnt = 0, s0 = 0;
  logic [7:0]  stb_addr = '0;
  logic [15:0] stb_data = '0;
  logic [63:0] r;
  logic        b;

  function automatic int mnext(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, sample 5 ns later, model advances at rising edge
  task automatic tick(input logic t, input logic d, output logic o);
    logic exp_en;
    @(negedge tck);
    tms_i = t; tdi_i = d;
    #5;
    o = tdo_o;
    exp_en = (mst == 4 || mst == 11);
    chk(tdo_en_o === exp_en, "R11 tdo_en", 64'(tdo_en_o), 64'(exp_en));
    if (prog_strobe_o === 1'b1) begin
      stb_cnt++; stb_addr = prog_addr_o; stb_data = prog_data_o;
    end
    @(posedge tck); #1;
    mst = mnext(mst, t);
  endtask

  task automatic tk(input logic t);
    logic o;
    tick(t, 1'b0, o);
  endtask

  task automatic go_ir(input logic [7:0] v, output logic [7:0] o);
    logic x;
    tk(1); tk(1); tk(0); tk(0);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, v[i], x); o[i] = x;
    end
    tk(1); tk(0);
  endtask

  task automatic go_dr(input int n, input logic [63:0] v, output logic [63:0] o);
    logic x;
    o = '0;
    tk(1); tk(0); tk(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, v[i], x); o[i] = x;
    end
    tk(1); tk(0);
  endtask

  task automatic bypass_check(input logic [7:0] op, input string req);
    logic [7:0] ir_o;
    go_ir(op, ir_o);
    go_dr(8, 64'h00000000000000B3, r);
    chk(r[7:0] === 8'h66, req, 64'(r[7:0]), 64'h66);
  endtask

  initial begin
    logic [7:0] ir_out;
    #50;
    // R1 reset values
    chk(tdo_en_o === 1'b0 && prog_strobe_o === 1'b0, "R1 reset outputs", 64'({tdo_en_o, prog_strobe_o}), 64'h0);
    chk(prog_addr_o === 8'h00 && prog_data_o === 16'h0000, "R1 reset latches", 64'({prog_addr_o, prog_data_o}), 64'h0);
    @(negedge tck); rst_ni = 1'b1; mst = 0;
    tk(0);
    // R1/R6: IDCODE is the default instruction
    go_dr(32, 64'h0, r);
    chk(r[31:0] === ID_VAL, "R1 R6 idcode after reset", r, 64'(ID_VAL));
    chk(r[0] === 1'b1, "R6 idcode lsb", 64'(r[0]), 64'h1);
    // R3 IR capture pattern, R4 bypass
    go_ir(8'hFF, ir_out);
    chk(ir_out === 8'h01, "R3 ir capture", 64'(ir_out), 64'h01);
    go_dr(8, 64'h00000000000000B3, r);
    chk(r[7:0] === 8'h66, "R4 bypass delay", 64'(r[7:0]), 64'h66);
    go_dr(8, 64'h000000000000005A, r);
    chk(r[7:0] === 8'hB4, "R4 bypass delay 2", 64'(r[7:0]), 64'hB4);
    // R5 boundary and undefined opcodes
    bypass_check(8'h00, "R5 extest");
    bypass_check(8'h01, "R5 sample");
    bypass_check(8'h02, "R5 clamp");
    bypass_check(8'h03, "R5 highz");
    bypass_check(8'h7E, "R5 undefined");
    // R2: five high mode cycles from Shift-DR
    go_ir(8'hFF, ir_out);
    tk(1); tk(0); tk(0);
    tk(1); tk(1); tk(1); tk(1); tk(1);
    chk(mst == 0, "R2 model in reset", 64'(mst), 64'h0);
    tk(0);
    go_dr(32, 64'h0, r);
    chk(r[31:0] === ID_VAL, "R2 idcode after five ones", r, 64'(ID_VAL));
    // R8 address and data registers
    go_ir(8'h11, ir_out);
    go_dr(8, 64'hA5, r);
    chk(prog_addr_o === 8'hA5, "R8 addr update", 64'(prog_addr_o), 64'hA5);
    go_dr(8, 64'h3C, r);
    chk(r[7:0] === 8'hA5, "R8 addr readback", 64'(r[7:0]), 64'hA5);
    chk(prog_addr_o === 8'h3C, "R8 addr update 2", 64'(prog_addr_o), 64'h3C);
    go_ir(8'h12, ir_out);
    go_dr(16, 64'h1234, r);
    chk(prog_data_o === 16'h1234, "R8 data update", 64'(prog_data_o), 64'h1234);
    go_dr(16, 64'hC0DE, r);
    chk(r[15:0] === 16'h1234, "R8 data readback", 64'(r[15:0]), 64'h1234);
    // R7 status capture
    cmp_i = 6'b101101;
    go_ir(8'h15, ir_out);
    go_dr(6, 64'h0, r);
    chk(r[5:0] === 6'b101101, "R7 status", 64'(r[5:0]), 64'h2D);
    cmp_i = 6'b010011;
    go_dr(6, 64'h0, r);
    chk(r[5:0] === 6'b010011, "R7 status 2", 64'(r[5:0]), 64'h13);
    // R10 read capture, data latch untouched
    rd_data_i = 16'hBEEF;
    go_ir(8'h14, ir_out);
    go_dr(16, 64'h5555, r);
    chk(r[15:0] === 16'hBEEF, "R10 read capture", 64'(r[15:0]), 64'hBEEF);
    chk(prog_data_o === 16'hC0DE, "R10 data kept", 64'(prog_data_o), 64'hC0DE);
    // R9 program strobe
    chk(stb_cnt == 0, "R9 no strobe before program", 64'(stb_cnt), 64'h0);
    s0 = stb_cnt;
    go_ir(8'h13, ir_out);
    tk(0); tk(0);
    chk(stb_cnt == s0 + 1, "R9 strobe on IR load", 64'(stb_cnt), 64'(s0 + 1));
    chk(stb_addr === 8'h3C && stb_data === 16'hC0DE, "R9 strobe addr/data",
        64'({stb_addr, stb_data}), 64'h3CC0DE);
    go_dr(1, 64'h0, r);
    tk(0);
    chk(stb_cnt == s0 + 2, "R9 strobe from update-dr", 64'(stb_cnt), 64'(s0 + 2));
    // load PROGRAM and leave Update-IR towards Select-DR: only the Update-DR pulse
    tk(1); tk(1); tk(0); tk(0);
    for (int i = 0; i < 8; i++) tick(i == 7, 1'(8'h13 >> i), b);
    tk(1); tk(1); tk(0); tk(1); tk(1); tk(0); tk(0);
    chk(stb_cnt == s0 + 3, "R9 no strobe via select-dr", 64'(stb_cnt), 64'(s0 + 3));
    // R12 asynchronous reset in Shift-DR
    go_ir(8'hFF, ir_out);
    tk(1); tk(0); tk(0);
    @(negedge tck); #3; rst_ni = 1'b0; tms_i = 1'b1; #2;
    chk(tdo_en_o === 1'b0, "R12 trst en low", 64'(tdo_en_o), 64'h0);
    @(posedge tck); @(negedge tck); rst_ni = 1'b1; mst = 0;
    tk(0);
    go_dr(32, 64'h0, r);
    chk(r[31:0] === ID_VAL, "R12 idcode after trst", r, 64'(ID_VAL));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule